// File: doc/BRIEF.md
# Hashed Page Table Walker

This block services a translation miss. A request carries a virtual segment identifier, an effective page number, a load/store flag and a translation-enable bit. When translation is enabled, the walker forms the address of a 64-byte entry group from a power-of-two sized table and inspects its eight 64-bit entries in turn through a single memory read/write port. The first valid entry whose tags match supplies the physical page number. The whole entry is also returned so that the caller can load it into its TLB.

Status bits are maintained during the walk. An entry found with its referenced bit clear is written back to memory with that bit set. A store also sets the changed bit. A store that hits a TLB entry whose changed bit is still clear is sent to this block as an ordinary request. The walker then repeats the full search, sets the changed bit in memory, and returns the whole entry for rewriting. When translation is disabled the block makes no memory access and returns the effective page number as the physical page number. Only one request is handled at a time.

Top module: `pt_walker`

## Requirements
- R1: The group address is `tbl_base | (((req_vsid[18:0] ^ req_epn[15:0]) & tbl_mask) << 6)`. The entry in slot i is read at the group address plus 8*i. `tbl_base` is a multiple of the table size.
- R2: Slots are read in ascending order starting at slot 0. The first matching entry ends the search, so a hit in slot k costs exactly k+1 reads.
- R3: An entry matches only if bit 63 (valid) is 1, bits 62:40 equal `req_vsid`, and bits 39:34 equal `req_epn[15:10]`.
- R4: If none of the eight slots matches, the response has `rsp_fault`=1 after exactly eight reads and no write.
- R5: On a hit, `rsp_fault`=0, `rsp_ppn` equals entry bits 31:12, and `rsp_pte` equals the entry as it stands in memory after any update.
- R6: A hit with the referenced bit (bit 8) clear writes the entry back, to the same address, with bit 8 set. A load hit with bit 8 already set performs no write.
- R7: A store hit sets the changed bit (bit 7) together with bit 8 in a single write. A store hit on an entry that already has both bits set performs no write.
- R8: A write-back alters no bit other than bits 8 and 7. Every other bit is written exactly as it was read.
- R9: With `req_xlate_en`=0, the response has `rsp_ppn`=`req_epn`, `rsp_fault`=0 and `rsp_pte`=0, and no memory request is made.
- R10: `req_ready` equals `!busy`. `busy` rises in the cycle after a request is accepted and stays high through the single-cycle `rsp_valid` pulse. It then falls.
- R11: While `mem_req_valid` is high and not yet accepted, the address, write flag and write data stay stable.
- R12: During reset, `busy`, `mem_req_valid` and `rsp_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vsid | input | 23 | Virtual segment identifier |
| req_epn | input | 20 | Effective page number; low 16 bits are the page index |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| req_xlate_en | input | 1 | Translation enable for this access type |
| tbl_base | input | 32 | Table base address |
| tbl_mask | input | 19 | Hash mask selecting the table size |
| busy | output | 1 | Request in progress |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_req_wdata | output | 64 | Entry written back |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 64 | Returned entry |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | No matching entry |
| rsp_ppn | output | 20 | Physical page number |
| rsp_pte | output | 64 | Full entry for the TLB |

## Verification
The assertions assume the memory returns exactly one `mem_rd_valid` pulse for each accepted read, and never while no read is outstanding. They also assume that `tbl_base`, `tbl_mask` and the request fields are held steady while `busy` is high. The bench memory model keeps a single read outstanding and returns it after a random delay of zero to two cycles. The bench changes the mask and table contents only between requests, when the walker is idle. Randomness is confined to the ready signal, the latency, the table contents and the choice of request.

// File: rtl/pt_pkg.sv
// Package: entry layout and walker state encoding shared by the walker,
// its sub-blocks and its checker. Assumes 64-bit entries, most significant
// bit first.
package pt_pkg;
    localparam int PTE_W       = 64;
    localparam int PTE_V_BIT   = 63;
    localparam int PTE_VSID_LO = 40;
    localparam int PTE_API_LO  = 34;
    localparam int PTE_PPN_LO  = 12;
    localparam int PTE_R_BIT   = 8;
    localparam int PTE_C_BIT   = 7;
    localparam int ENTRY_BYTES = 8;

    typedef enum logic [2:0] {
        WALK_IDLE,
        WALK_RD_REQ,
        WALK_RD_WAIT,
        WALK_WR_REQ,
        WALK_RESP
    } walk_st_e;
endpackage

// File: rtl/pt_hash.sv
// Entry address generator: folds the segment id and page index into a
// group number, masks it to the table size and merges it into the base.
// Assumes the base is aligned to the table size, so OR acts as ADD.
module pt_hash #(
    parameter int ADDR_W = 32,
    parameter int VSID_W = 23,
    parameter int PIDX_W = 16,
    parameter int HASH_W = 19,
    parameter int SLOTS  = 8
) (
    input  logic [ADDR_W-1:0]          base,
    input  logic [HASH_W-1:0]          mask,
    input  logic [VSID_W-1:0]          vsid,
    input  logic [PIDX_W-1:0]          pidx,
    input  logic [$clog2(SLOTS)-1:0]   slot,
    output logic [ADDR_W-1:0]          addr
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int ENT_SH = $clog2(pt_pkg::ENTRY_BYTES);
    localparam int GRP_SH = ENT_SH + SLOT_W;

    logic [HASH_W-1:0] vsid_h;
    logic [HASH_W-1:0] pidx_h;
    logic [HASH_W-1:0] hash;

    // Fit the segment id to the hash width.
    if (VSID_W >= HASH_W) begin : g_vsid_trunc
        assign vsid_h = vsid[HASH_W-1:0];
    end else begin : g_vsid_ext
        assign vsid_h = {{(HASH_W-VSID_W){1'b0}}, vsid};
    end

    // Fit the page index to the hash width.
    if (PIDX_W >= HASH_W) begin : g_pidx_trunc
        assign pidx_h = pidx[HASH_W-1:0];
    end else begin : g_pidx_ext
        assign pidx_h = {{(HASH_W-PIDX_W){1'b0}}, pidx};
    end

    // Form the masked hash and the final entry address.
    always_comb begin
        hash = (vsid_h ^ pidx_h) & mask;
        addr = base
             | ({{(ADDR_W-HASH_W){1'b0}}, hash} << GRP_SH)
             | ({{(ADDR_W-SLOT_W){1'b0}}, slot} << ENT_SH);
    end
endmodule

// File: rtl/pt_match.sv
// Tag comparator: reports whether a fetched entry is valid and carries the
// wanted segment id and abbreviated page index (top bits of the index).
module pt_match #(
    parameter int VSID_W = 23,
    parameter int PIDX_W = 16,
    parameter int API_W  = 6
) (
    input  logic [pt_pkg::PTE_W-1:0] pte,
    input  logic [VSID_W-1:0]        vsid,
    input  logic [PIDX_W-1:0]        pidx,
    output logic                     hit
);
    import pt_pkg::*;

    // Compare valid bit and both tags in one step.
    always_comb begin
        hit = pte[PTE_V_BIT]
            && (pte[PTE_VSID_LO +: VSID_W] == vsid)
            && (pte[PTE_API_LO +: API_W] == pidx[PIDX_W-1 -: API_W]);
    end
endmodule

// File: rtl/pt_status_upd.sv
// Status-bit updater: sets referenced, and changed for stores, leaving every
// other bit untouched; flags when memory must be rewritten.
module pt_status_upd (
    input  logic [pt_pkg::PTE_W-1:0] pte_in,
    input  logic                     is_store,
    output logic [pt_pkg::PTE_W-1:0] pte_out,
    output logic                     need_wr
);
    import pt_pkg::*;

    // Merge the status bits and detect a difference.
    always_comb begin
        pte_out            = pte_in;
        pte_out[PTE_R_BIT] = 1'b1;
        if (is_store) pte_out[PTE_C_BIT] = 1'b1;
        need_wr            = (pte_out != pte_in);
    end
endmodule

// File: rtl/pt_walker.sv
// Hashed page table walker top. Accepts one request at a time, scans the
// eight slots of the hashed group in order, updates status bits in memory
// and returns the entry or a fault. Assumes the memory returns exactly one
// read-data pulse per accepted read and that table base and mask stay
// steady while busy.
module pt_walker #(
    parameter int ADDR_W = 32,
    parameter int VSID_W = 23,
    parameter int EPN_W  = 20,
    parameter int PIDX_W = 16,
    parameter int API_W  = 6,
    parameter int HASH_W = 19,
    parameter int PPN_W  = 20,
    parameter int SLOTS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [VSID_W-1:0]        req_vsid,
    input  logic [EPN_W-1:0]         req_epn,
    input  logic                     req_store,
    input  logic                     req_xlate_en,
    input  logic [ADDR_W-1:0]        tbl_base,
    input  logic [HASH_W-1:0]        tbl_mask,
    output logic                     busy,
    output logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    output logic                     mem_req_write,
    output logic [ADDR_W-1:0]        mem_req_addr,
    output logic [pt_pkg::PTE_W-1:0] mem_req_wdata,
    input  logic                     mem_rd_valid,
    input  logic [pt_pkg::PTE_W-1:0] mem_rd_data,
    output logic                     rsp_valid,
    output logic                     rsp_fault,
    output logic [PPN_W-1:0]         rsp_ppn,
    output logic [pt_pkg::PTE_W-1:0] rsp_pte
);
    import pt_pkg::*;

    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    walk_st_e           st_q;
    logic [SLOT_W-1:0]  slot_q;
    logic [VSID_W-1:0]  vsid_q;
    logic [PIDX_W-1:0]  pidx_q;
    logic               store_q;
    logic               fault_q;
    logic [PPN_W-1:0]   ppn_q;
    logic [PTE_W-1:0]   pte_q;

    logic [ADDR_W-1:0]  ent_addr;
    logic               ent_hit;
    logic [PTE_W-1:0]   upd_pte;
    logic               upd_need;

    pt_hash #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W),
        .HASH_W(HASH_W), .SLOTS(SLOTS)
    ) u_hash (
        .base(tbl_base), .mask(tbl_mask), .vsid(vsid_q),
        .pidx(pidx_q), .slot(slot_q), .addr(ent_addr)
    );

    pt_match #(
        .VSID_W(VSID_W), .PIDX_W(PIDX_W), .API_W(API_W)
    ) u_match (
        .pte(mem_rd_data), .vsid(vsid_q), .pidx(pidx_q), .hit(ent_hit)
    );

    pt_status_upd u_upd (
        .pte_in(mem_rd_data), .is_store(store_q),
        .pte_out(upd_pte), .need_wr(upd_need)
    );

    // Sequence the walk: accept, read slots, optional write-back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WALK_IDLE;
            slot_q <= '0;
        end else begin
            case (st_q)
                WALK_IDLE: if (req_valid) begin
                    slot_q <= '0;
                    st_q   <= req_xlate_en ? WALK_RD_REQ : WALK_RESP;
                end
                WALK_RD_REQ: if (mem_req_ready) st_q <= WALK_RD_WAIT;
                WALK_RD_WAIT: if (mem_rd_valid) begin
                    if (ent_hit)
                        st_q <= upd_need ? WALK_WR_REQ : WALK_RESP;
                    else if (slot_q == LAST_SLOT)
                        st_q <= WALK_RESP;
                    else begin
                        slot_q <= slot_q + 1'b1;
                        st_q   <= WALK_RD_REQ;
                    end
                end
                WALK_WR_REQ: if (mem_req_ready) st_q <= WALK_RESP;
                WALK_RESP:   st_q <= WALK_IDLE;
                default:     st_q <= WALK_IDLE;
            endcase
        end
    end

    // Capture request fields and build the response contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vsid_q  <= '0;
            pidx_q  <= '0;
            store_q <= 1'b0;
            fault_q <= 1'b0;
            ppn_q   <= '0;
            pte_q   <= '0;
        end else if (st_q == WALK_IDLE && req_valid) begin
            vsid_q  <= req_vsid;
            pidx_q  <= req_epn[PIDX_W-1:0];
            store_q <= req_store;
            fault_q <= 1'b0;
            ppn_q   <= req_xlate_en ? '0 : req_epn[PPN_W-1:0];
            pte_q   <= '0;
        end else if (st_q == WALK_RD_WAIT && mem_rd_valid) begin
            if (ent_hit) begin
                pte_q <= upd_pte;
                ppn_q <= upd_pte[PTE_PPN_LO +: PPN_W];
            end else if (slot_q == LAST_SLOT) begin
                fault_q <= 1'b1;
            end
        end
    end

    // Drive the handshake and memory port from the current state.
    always_comb begin
        req_ready     = (st_q == WALK_IDLE);
        busy          = (st_q != WALK_IDLE);
        mem_req_valid = (st_q == WALK_RD_REQ) || (st_q == WALK_WR_REQ);
        mem_req_write = (st_q == WALK_WR_REQ);
        mem_req_addr  = ent_addr;
        mem_req_wdata = pte_q;
        rsp_valid     = (st_q == WALK_RESP);
        rsp_fault     = fault_q;
        rsp_ppn       = ppn_q;
        rsp_pte       = pte_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol checker for the walker, bound to every instance. Tracks reads,
// writes and bypass requests per walk with its own counters.
module pt_walker_chk #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_ready,
    input  logic                     req_xlate_en,
    input  logic                     busy,
    input  logic                     mem_req_valid,
    input  logic                     mem_req_ready,
    input  logic                     mem_req_write,
    input  logic [ADDR_W-1:0]        mem_req_addr,
    input  logic [pt_pkg::PTE_W-1:0] mem_req_wdata,
    input  logic                     mem_rd_valid,
    input  logic [pt_pkg::PTE_W-1:0] mem_rd_data,
    input  logic                     rsp_valid,
    input  logic                     rsp_fault
);
    import pt_pkg::*;

    localparam logic [PTE_W-1:0] STAT_MASK =
        (PTE_W'(1) << PTE_R_BIT) | (PTE_W'(1) << PTE_C_BIT);

    logic             accept;
    logic             rd_acc;
    logic             wr_acc;
    logic [4:0]       rd_cnt;
    logic [1:0]       wr_cnt;
    logic             byp_q;
    logic [PTE_W-1:0] last_rd;

    assign accept = req_valid && req_ready;
    assign rd_acc = mem_req_valid && mem_req_ready && !mem_req_write;
    assign wr_acc = mem_req_valid && mem_req_ready && mem_req_write;

    // Per-walk read/write counts, bypass flag and last returned entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_cnt  <= '0;
            wr_cnt  <= '0;
            byp_q   <= 1'b0;
            last_rd <= '0;
        end else begin
            if (accept) begin
                rd_cnt <= '0;
                wr_cnt <= '0;
                byp_q  <= !req_xlate_en;
            end else begin
                if (rd_acc) rd_cnt <= rd_cnt + 1'b1;
                if (wr_acc) wr_cnt <= wr_cnt + 1'b1;
                if (rsp_valid) byp_q <= 1'b0;
            end
            if (mem_rd_valid) last_rd <= mem_rd_data;
        end
    end

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !mem_req_valid && !rsp_valid));

    // R10
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == !busy);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R10
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && !busy);

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr)
             && $stable(mem_req_write) && $stable(mem_req_wdata)));

    // R2
    read_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> (rd_cnt < 5'(SLOTS)));

    // R4
    fault_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rd_cnt == 5'(SLOTS) && wr_cnt == 2'd0));

    // R8
    wb_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> (((mem_req_wdata ^ last_rd) & ~STAT_MASK) == '0
                    && mem_req_wdata[PTE_R_BIT]));

    // R7
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |-> (wr_cnt == 2'd0));

    // R9
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byp_q |-> (!mem_req_valid && !rsp_fault));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_xlate_en(req_xlate_en), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault)
);

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam int TBL_N = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [22:0] req_vsid = '0;
    logic [19:0] req_epn = '0;
    logic        req_store = 1'b0;
    logic        req_xlate_en = 1'b0;
    logic [31:0] tbl_base = BASE;
    logic [18:0] tbl_mask = 19'hF;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [63:0] mem_req_wdata;
    logic        mem_rd_valid = 1'b0;
    logic [63:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [19:0] rsp_ppn;
    logic [63:0] rsp_pte;

    int checks = 0;
    int errors = 0;

    logic [63:0] tbl [TBL_N];
    int          rd_n, wr_n;
    logic [31:0] rd_log [16];
    logic [31:0] wr_addr;
    logic        pend = 1'b0;
    int          dly;
    int          pend_idx;

    always #2 clk = ~clk;

    pt_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vsid(req_vsid), .req_epn(req_epn), .req_store(req_store),
        .req_xlate_en(req_xlate_en), .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_ppn(rsp_ppn), .rsp_pte(rsp_pte)
    );

    function automatic int addr_idx(logic [31:0] a);
        return int'((a - BASE) >> 3);
    endfunction

    // Memory model: random ready, one outstanding read, 0..2 cycle latency.
    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (pend) begin
            if (dly == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= tbl[pend_idx];
                pend         <= 1'b0;
            end else dly <= dly - 1;
        end
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                tbl[addr_idx(mem_req_addr) % TBL_N] <= mem_req_wdata;
                wr_addr <= mem_req_addr;
                wr_n    <= wr_n + 1;
            end else begin
                pend     <= 1'b1;
                dly      <= int'($urandom_range(0, 2));
                pend_idx <= addr_idx(mem_req_addr) % TBL_N;
                if (rd_n < 16) rd_log[rd_n] <= mem_req_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    always @(negedge clk) mem_req_ready <= ($urandom_range(0, 3) != 0);

    task automatic chk(string rq, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_pte(logic v, logic [22:0] vs, logic [5:0] api,
                                           logic [19:0] ppn, logic r, logic c);
        logic [63:0] p;
        p = {$urandom(), $urandom()};
        p[63] = v; p[62:40] = vs; p[39:34] = api; p[31:12] = ppn;
        p[8] = r; p[7] = c;
        return p;
    endfunction

    function automatic int grp(logic [22:0] vs, logic [15:0] pidx, logic [18:0] m);
        return int'((vs[18:0] ^ {3'b0, pidx}) & m);
    endfunction

    task automatic fill_noise();
        for (int i = 0; i < TBL_N; i++)
            tbl[i] = mk_pte($urandom_range(0, 1), 23'h7F0000 | 23'($urandom_range(0, 65535)),
                            6'($urandom()), 20'($urandom()), 1'($urandom()), 1'($urandom()));
    endtask

    // Issue one request and check it against a model of the requirements.
    task automatic walk(logic [22:0] vs, logic [19:0] epn, logic st, logic en);
        int g, hit_slot, exp_reads, wait_n;
        logic [63:0] orig, expv;
        g = grp(vs, epn[15:0], tbl_mask);
        hit_slot = -1;
        for (int s = 0; s < 8; s++) begin
            logic [63:0] e;
            e = tbl[g*8 + s];
            if (hit_slot < 0 && e[63] && e[62:40] == vs && e[39:34] == epn[15:10])
                hit_slot = s;
        end
        orig = (hit_slot >= 0) ? tbl[g*8 + hit_slot] : 64'h0;
        expv = orig;
        if (hit_slot >= 0) begin
            expv[8] = 1'b1;
            if (st) expv[7] = 1'b1;
        end
        rd_n = 0; wr_n = 0;
        @(negedge clk);
        req_valid = 1'b1; req_vsid = vs; req_epn = epn;
        req_store = st; req_xlate_en = en;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy after accept", {63'b0, busy}, 64'd1);
        chk("R10 ready low while busy", {63'b0, req_ready}, 64'd0);
        wait_n = 0;
        while (!rsp_valid && wait_n < 300) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R10 response arrives", {63'b0, rsp_valid}, 64'd1);
        if (!en) begin
            chk("R9 bypass ppn", {44'b0, rsp_ppn}, {44'b0, epn});
            chk("R9 bypass fault", {63'b0, rsp_fault}, 64'd0);
            chk("R9 bypass pte", rsp_pte, 64'd0);
            chk("R9 no memory traffic", 64'(rd_n + wr_n), 64'd0);
        end else if (hit_slot < 0) begin
            chk("R4 fault", {63'b0, rsp_fault}, 64'd1);
            chk("R4 eight reads", 64'(rd_n), 64'd8);
            chk("R4 no write", 64'(wr_n), 64'd0);
        end else begin
            exp_reads = hit_slot + 1;
            chk("R5 no fault", {63'b0, rsp_fault}, 64'd0);
            chk("R5 ppn", {44'b0, rsp_ppn}, {44'b0, orig[31:12]});
            chk("R5 pte", rsp_pte, expv);
            chk("R2 read count", 64'(rd_n), 64'(exp_reads));
            chk("R6 R7 write count", 64'(wr_n), (expv != orig) ? 64'd1 : 64'd0);
            chk("R8 memory after update", tbl[g*8 + hit_slot], expv);
            if (wr_n == 1)
                chk("R6 write address", {32'b0, wr_addr}, {32'b0, BASE | 32'(g*64 + hit_slot*8)});
        end
        if (en) begin
            for (int s = 0; s < 8 && s < rd_n; s++)
                chk("R1 R2 read address", {32'b0, rd_log[s]}, {32'b0, BASE | 32'(g*64 + s*8)});
        end
        @(negedge clk);
        chk("R10 idle after response", {62'b0, busy, rsp_valid}, 64'd0);
    endtask

    // Watchdog: an expired run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [22:0] vs;
        logic [19:0] epn;
        int g;
        void'($urandom(32'd20240611));
        rd_n = 0; wr_n = 0; dly = 0; pend_idx = 0; wr_addr = '0;
        fill_noise();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12 reset state
        chk("R12 busy in reset", {63'b0, busy}, 64'd0);
        chk("R12 mem valid in reset", {63'b0, mem_req_valid}, 64'd0);
        chk("R12 rsp valid in reset", {63'b0, rsp_valid}, 64'd0);
        rst_n = 1'b1;

        // R6: load hit in slot 0 with referenced clear.
        vs = 23'h012345; epn = 20'hA_C401; g = grp(vs, epn[15:0], tbl_mask);
        tbl[g*8] = mk_pte(1, vs, epn[15:10], 20'h5A5A5, 0, 0);
        walk(vs, epn, 0, 1);
        // R6: same entry again as a load, referenced now set, no write.
        walk(vs, epn, 0, 1);
        // R7: store on it sets changed only.
        walk(vs, epn, 1, 1);
        // R7: store again, both set, no write.
        walk(vs, epn, 1, 1);

        // R2 R7: hit in the last slot by a store with referenced set.
        fill_noise();
        vs = 23'h000777; epn = 20'h3_1234; g = grp(vs, epn[15:0], tbl_mask);
        tbl[g*8 + 7] = mk_pte(1, vs, epn[15:10], 20'hFEDCB, 1, 0);
        walk(vs, epn, 1, 1);

        // R3 R4: near misses only (invalid, wrong api, wrong vsid).
        fill_noise();
        vs = 23'h00ABCD; epn = 20'h0_8F00; g = grp(vs, epn[15:0], tbl_mask);
        tbl[g*8 + 1] = mk_pte(0, vs, epn[15:10], 20'h11111, 0, 0);
        tbl[g*8 + 3] = mk_pte(1, vs, epn[15:10] ^ 6'h01, 20'h22222, 0, 0);
        tbl[g*8 + 6] = mk_pte(1, vs ^ 23'h400000, epn[15:10], 20'h33333, 0, 0);
        walk(vs, epn, 0, 1);

        // R2: duplicates in slots 2 and 5, first wins.
        vs = 23'h0F0F0F; epn = 20'h7_7777; g = grp(vs, epn[15:0], tbl_mask);
        tbl[g*8 + 2] = mk_pte(1, vs, epn[15:10], 20'hAAAAA, 0, 0);
        tbl[g*8 + 5] = mk_pte(1, vs, epn[15:10], 20'hBBBBB, 0, 0);
        walk(vs, epn, 0, 1);

        // R9: bypass with translation disabled.
        walk(23'h1, 20'hC_AFE5, 1, 0);

        // R1: narrower mask folds hash bits above it.
        tbl_mask = 19'h3;
        vs = 23'h00004C; epn = 20'h0_0008; g = grp(vs, epn[15:0], tbl_mask);
        tbl[g*8 + 4] = mk_pte(1, vs, epn[15:10], 20'h0BEEF, 0, 0);
        walk(vs, epn, 0, 1);

        // Random mix of hits, misses, stores and bypasses.
        for (int n = 0; n < 80; n++) begin
            case ($urandom_range(0, 2))
                0: tbl_mask = 19'h3;
                1: tbl_mask = 19'h7;
                default: tbl_mask = 19'hF;
            endcase
            vs  = 23'($urandom_range(0, 31)) << 2;
            epn = 20'($urandom());
            g   = grp(vs, epn[15:0], tbl_mask);
            if ($urandom_range(0, 9) < 7)
                tbl[g*8 + $urandom_range(0, 7)] = mk_pte(1, vs, epn[15:10],
                    20'($urandom()), 1'($urandom()), 1'($urandom()));
            walk(vs, epn, 1'($urandom()), $urandom_range(0, 9) != 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule